// File: doc/BRIEF.md
# Microcontroller Data Memory Router

This unit sits between the operand side of an 8-bit microcontroller core and the storage behind it. For each operand access it chooses one target. The targets are a 256-byte internal RAM, an on-chip auxiliary RAM at the bottom of the external data space, and an outward bus to the special-function registers (SFRs). The core supplies an access-mode code, a 16-bit address, write data, a write flag and the two register-bank bits of its status word. The router returns read data and drives the SFR strobes.

The address alone does not fix the target. A byte address from 80h to FFh reaches the upper internal RAM when it comes through a pointer register, and it reaches the SFR bus when it is given directly. Register-mode and pointer-based accesses are relative to the active bank. Single-bit accesses decode into either the bit-addressable RAM bytes or the SFRs whose address is a multiple of eight. A bit write is carried out as a read-modify-write of the containing byte within one cycle.

Top module: `dmem_router`

## Requirements
- R1: Mode 0 (register) with register number r = addr[2:0] and bank b = psw_bank reaches internal RAM byte {b, r}, i.e. b*8 + r. Each bank's R7 and the next bank's R0 are distinct bytes.
- R2: Mode 3 (bit) with a bit address below 80h selects internal RAM byte 20h + addr[6:3], bit addr[2:0]. The same bytes can also be read and written as whole bytes in mode 1.
- R3: Mode 1 (direct) with an address below 80h reads and writes internal RAM, and the SFR strobes stay low.
- R4: Mode 2 (indirect) uses as its address the content of R0 (addr[0]=0) or R1 (addr[0]=1) in the active bank. It reaches all 256 internal RAM bytes, including 80h–FFh, and never strobes the SFR bus.
- R5: Mode 1 with an address of 80h–FFh drives sfr_addr with that address. It raises sfr_rd for a read and sfr_wr for a write in the request cycle, and a read returns sfr_rdata.
- R6: Mode 3 with a bit address of 80h or above selects SFR {addr[7:3], 000b}, bit addr[2:0]. A bit write raises sfr_rd and sfr_wr together, and sfr_wdata equals sfr_rdata with only the selected bit replaced.
- R7: A bit write stores acc_wdata[0] into the selected bit and leaves the other seven bits of the byte unchanged. A bit read returns the bit in rd_data[0], with rd_data[7:1] zero.
- R8: Mode 5 (data pointer) reaches auxiliary RAM byte addr[15:0]. Mode 4 reaches auxiliary RAM byte R0/R1 (picked by addr[0], active bank). The RAM size AUX_BYTES is a parameter with a default of 768.
- R9: A mode 5 access at or above AUX_BYTES reads FFh, and a write there changes no auxiliary RAM byte.
- R10: The result of a read request (acc_en=1, acc_wr=0) appears on rd_data one clock later. rd_data keeps its value through idle and write cycles, and a write lands at the clock edge where it is requested.
- R11: Mode codes 6 and 7 are reserved. They write nothing, strobe nothing and read 00h. Reset clears rd_data and the internal RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_mode | input | 3 | Access mode code (0 reg, 1 direct, 2 indirect, 3 bit, 4 ext via R0/R1, 5 ext via pointer) |
| acc_addr | input | 16 | Address, register number or bit address |
| acc_wr | input | 1 | Write when high, read when low |
| acc_wdata | input | 8 | Write byte; bit 0 is the bit value in mode 3 |
| psw_bank | input | 2 | Active register bank |
| rd_data | output | 8 | Read result, one cycle after the request |
| sfr_addr | output | 8 | SFR bus address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid in the same cycle |

## Verification
The hardest case to reach from the ports is one byte address in 80h–FFh holding two different values at once: one in upper RAM and one in an SFR. To get there, the bench first loads a pointer register in a chosen bank through register mode. It then writes upper RAM through that pointer and writes the SFR model directly at the same address. Finally it reads both paths back, so that a swapped route shows up as the other path's value. The bank walk writes all 32 register slots with distinct values and reads them back as direct bytes, which exposes any wrap error at a bank edge.

// File: rtl/dmem_pkg.sv
// Shared mode codes, target kinds and the decoded route record.
package dmem_pkg;
    localparam logic [2:0] MODE_REG = 3'd0;
    localparam logic [2:0] MODE_DIR = 3'd1;
    localparam logic [2:0] MODE_IND = 3'd2;
    localparam logic [2:0] MODE_BIT = 3'd3;
    localparam logic [2:0] MODE_XRI = 3'd4;
    localparam logic [2:0] MODE_XDP = 3'd5;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_IRAM,
        TGT_SFR,
        TGT_AUX,
        TGT_VOID
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [7:0] iaddr;
        logic       is_bit;
        logic [2:0] bpos;
    } route_t;
endpackage

// File: rtl/dmem_addr_decode.sv
// Address decoder: turns mode, address, bank and pointer value into a route.
// Assumes ptr_val is the internal RAM byte at ptr_idx (combinational read).
module dmem_addr_decode
    import dmem_pkg::*;
#(
    parameter int AUX_BYTES = 768,
    parameter int AUX_AW    = $clog2(AUX_BYTES)
) (
    input  logic [2:0]        mode,
    input  logic [15:0]       addr,
    input  logic [1:0]        bank,
    input  logic [7:0]        ptr_val,
    output logic [7:0]        ptr_idx,
    output route_t            route,
    output logic [AUX_AW-1:0] xidx
);
    localparam logic [16:0] AUX_LIM = 17'(AUX_BYTES);

    // Pointer register R0/R1 inside the active bank.
    always_comb ptr_idx = {3'b000, bank, 2'b00, addr[0]};

    // Route selection per access mode.
    always_comb begin
        route        = '{tgt: TGT_NONE, iaddr: 8'h00, is_bit: 1'b0, bpos: 3'd0};
        xidx         = '0;
        unique case (mode)
            MODE_REG: begin
                route.tgt   = TGT_IRAM;
                route.iaddr = {3'b000, bank, addr[2:0]};
            end
            MODE_DIR: begin
                route.tgt   = addr[7] ? TGT_SFR : TGT_IRAM;
                route.iaddr = addr[7:0];
            end
            MODE_IND: begin
                route.tgt   = TGT_IRAM;
                route.iaddr = ptr_val;
            end
            MODE_BIT: begin
                route.is_bit = 1'b1;
                route.bpos   = addr[2:0];
                if (addr[7]) begin
                    route.tgt   = TGT_SFR;
                    route.iaddr = {addr[7:3], 3'b000};
                end else begin
                    route.tgt   = TGT_IRAM;
                    route.iaddr = {4'h2, addr[6:3]};
                end
            end
            MODE_XRI: begin
                route.tgt = ({9'h000, ptr_val} < AUX_LIM) ? TGT_AUX : TGT_VOID;
                xidx      = AUX_AW'(ptr_val);
            end
            MODE_XDP: begin
                route.tgt = ({1'b0, addr} < AUX_LIM) ? TGT_AUX : TGT_VOID;
                xidx      = addr[AUX_AW-1:0];
            end
            default: route.tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/dmem_iram.sv
// Internal RAM: DEPTH bytes, two combinational read ports, one write port.
// Port A serves the pointer fetch, port B the operand. Cleared on reset.
module dmem_iram #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] mem [DEPTH];

    // Byte store with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read ports.
    always_comb begin
        ra_data = mem[ra_addr];
        rb_data = mem[rb_addr];
    end
endmodule

// File: rtl/dmem_aux_ram.sv
// Auxiliary RAM in the low external data space. Single port, combinational
// read. Assumes the caller only enables writes for in-range indices.
module dmem_aux_ram #(
    parameter int BYTES = 768,
    parameter int DW    = 8,
    parameter int AW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [BYTES];

    // Byte store.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Combinational read, guarded against out-of-range indices.
    always_comb rdata = (int'(addr) < BYTES) ? mem[addr] : '1;
endmodule

// File: rtl/dmem_bit_rmw.sv
// Bit merge: extracts one bit of a byte and builds the byte to write back.
// For byte accesses the write data passes through unchanged.
module dmem_bit_rmw #(
    parameter int DW = 8,
    parameter int BW = $clog2(DW)
) (
    input  logic [DW-1:0] old_byte,
    input  logic [BW-1:0] bpos,
    input  logic          is_bit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] new_byte,
    output logic          bit_out
);
    logic [DW-1:0] mask;

    // One-hot mask of the selected bit.
    always_comb mask = DW'(1) << bpos;

    // Merge and extract.
    always_comb begin
        bit_out  = old_byte[bpos];
        new_byte = is_bit ? ((old_byte & ~mask) | (wdata[0] ? mask : '0)) : wdata;
    end
endmodule

// File: rtl/dmem_router.sv
// Data memory router top. Decodes each access and steers it to internal RAM,
// auxiliary RAM or the SFR bus. Assumes sfr_rdata is valid combinationally
// in the cycle sfr_rd is high. Reads register into rd_data one clock later.
module dmem_router
    import dmem_pkg::*;
#(
    parameter int AUX_BYTES = 768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic [2:0]  acc_mode,
    input  logic [15:0] acc_addr,
    input  logic        acc_wr,
    input  logic [7:0]  acc_wdata,
    input  logic [1:0]  psw_bank,
    output logic [7:0]  rd_data,
    output logic [7:0]  sfr_addr,
    output logic        sfr_rd,
    output logic        sfr_wr,
    output logic [7:0]  sfr_wdata,
    input  logic [7:0]  sfr_rdata
);
    localparam int AUX_AW = $clog2(AUX_BYTES);
    localparam int DW     = 8;
    localparam int IDEPTH = 256;

    route_t            route;
    logic [7:0]        ptr_idx;
    logic [7:0]        ptr_val;
    logic [AUX_AW-1:0] xidx;
    logic [DW-1:0]     iram_rd;
    logic [DW-1:0]     aux_rd;
    logic [DW-1:0]     old_byte;
    logic [DW-1:0]     new_byte;
    logic              bit_out;
    logic              do_wr;
    logic              do_rd;

    dmem_addr_decode #(.AUX_BYTES(AUX_BYTES), .AUX_AW(AUX_AW)) u_dec (
        .mode    (acc_mode),
        .addr    (acc_addr),
        .bank    (psw_bank),
        .ptr_val (ptr_val),
        .ptr_idx (ptr_idx),
        .route   (route),
        .xidx    (xidx)
    );

    dmem_iram #(.DEPTH(IDEPTH), .DW(DW)) u_iram (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (ptr_idx),
        .rb_addr (route.iaddr),
        .we      (do_wr && route.tgt == TGT_IRAM),
        .waddr   (route.iaddr),
        .wdata   (new_byte),
        .ra_data (ptr_val),
        .rb_data (iram_rd)
    );

    dmem_aux_ram #(.BYTES(AUX_BYTES), .DW(DW), .AW(AUX_AW)) u_aux (
        .clk   (clk),
        .we    (do_wr && route.tgt == TGT_AUX),
        .addr  (xidx),
        .wdata (new_byte),
        .rdata (aux_rd)
    );

    dmem_bit_rmw #(.DW(DW)) u_rmw (
        .old_byte (old_byte),
        .bpos     (route.bpos),
        .is_bit   (route.is_bit),
        .wdata    (acc_wdata),
        .new_byte (new_byte),
        .bit_out  (bit_out)
    );

    // Request qualifiers.
    always_comb begin
        do_wr = acc_en && acc_wr;
        do_rd = acc_en && !acc_wr;
    end

    // Current byte at the selected target.
    always_comb begin
        unique case (route.tgt)
            TGT_IRAM: old_byte = iram_rd;
            TGT_SFR:  old_byte = sfr_rdata;
            TGT_AUX:  old_byte = aux_rd;
            TGT_VOID: old_byte = 8'hFF;
            default:  old_byte = 8'h00;
        endcase
    end

    // SFR bus strobes; a bit write also reads for its merge.
    always_comb begin
        sfr_addr  = route.iaddr;
        sfr_wdata = new_byte;
        sfr_wr    = do_wr && route.tgt == TGT_SFR;
        sfr_rd    = acc_en && route.tgt == TGT_SFR && (!acc_wr || route.is_bit);
    end

    // Registered read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (do_rd) begin
            rd_data <= route.is_bit ? {7'b0, bit_out} : old_byte;
        end
    end
endmodule

// File: rtl/dmem_router_chk.sv
// Property checker for dmem_router, attached by bind below.
module dmem_router_chk
    import dmem_pkg::*;
#(
    parameter int AUX_BYTES = 768
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic [2:0]  acc_mode,
    input logic [15:0] acc_addr,
    input logic        acc_wr,
    input logic        bit_in,
    input logic [7:0]  rd_data,
    input logic [7:0]  sfr_addr,
    input logic        sfr_rd,
    input logic        sfr_wr,
    input logic [7:0]  sfr_wdata,
    input logic [7:0]  sfr_rdata
);
    localparam logic [16:0] AUX_LIM = 17'(AUX_BYTES);

    a_r3_low_direct_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == MODE_DIR && !acc_addr[7]) |-> (!sfr_rd && !sfr_wr));

    a_r4_indirect_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == MODE_IND) |-> (!sfr_rd && !sfr_wr));

    a_r5_direct_high_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == MODE_DIR && acc_addr[7])
        |-> (sfr_addr == acc_addr[7:0] && (acc_wr ? (sfr_wr && !sfr_rd) : (sfr_rd && !sfr_wr))));

    a_r6_sfr_bit_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == MODE_BIT && acc_addr[7])
        |-> (sfr_addr == {acc_addr[7:3], 3'b000} && sfr_rd));

    a_r6_sfr_bit_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && acc_mode == MODE_BIT)
        |-> (((sfr_wdata ^ sfr_rdata) & ~(8'h01 << acc_addr[2:0])) == 8'h00
             && sfr_wdata[acc_addr[2:0]] == bit_in));

    a_r9_void_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_mode == MODE_XDP && {1'b0, acc_addr} >= AUX_LIM)
        |=> (rd_data == 8'hFF));

    a_r10_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> $stable(rd_data));

    a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode[2:1] == 2'b11) |-> (!sfr_rd && !sfr_wr));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_mode[2:1] == 2'b11) |=> (rd_data == 8'h00));

    a_r5_strobe_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd || sfr_wr) |-> acc_en);
endmodule

bind dmem_router dmem_router_chk #(.AUX_BYTES(AUX_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_mode  (acc_mode),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .bit_in    (acc_wdata[0]),
    .rd_data   (rd_data),
    .sfr_addr  (sfr_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata)
);

// File: tb/dmem_router_tb.sv
`timescale 1ns/1ps
// Directed bench for dmem_router with a behavioural SFR bus model.
module dmem_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_mode = 3'd0;
    logic [15:0] acc_addr = 16'h0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_wdata = 8'h0;
    logic [1:0]  psw_bank = 2'd0;
    logic [7:0]  rd_data;
    logic [7:0]  sfr_addr;
    logic        sfr_rd;
    logic        sfr_wr;
    logic [7:0]  sfr_wdata;
    logic [7:0]  sfr_rdata;
    logic [7:0]  sfr_mem [256];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic       seen_rd;
    logic       seen_wr;
    logic [7:0] seen_addr;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    dmem_router #(.AUX_BYTES(768)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_mode(acc_mode),
        .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .psw_bank(psw_bank), .rd_data(rd_data), .sfr_addr(sfr_addr),
        .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata)
    );

    // SFR model: preset to addr ^ 5Ah during reset, written on sfr_wr.
    assign sfr_rdata = sfr_mem[sfr_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) sfr_mem[i] <= 8'(i) ^ 8'h5A;
        end else if (sfr_wr) begin
            sfr_mem[sfr_addr] <= sfr_wdata;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One access cycle; rd_data is sampled one clock later into rv.
    task automatic acc(input logic [2:0] m, input logic [15:0] a, input logic w,
                       input logic [7:0] d, input logic [1:0] b);
        @(negedge clk);
        acc_en = 1'b1; acc_mode = m; acc_addr = a; acc_wr = w; acc_wdata = d; psw_bank = b;
        #1;
        seen_rd = sfr_rd; seen_wr = sfr_wr; seen_addr = sfr_addr;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        rv = rd_data;
    endtask

    task automatic t_reset();
        chk("R11 reset rd_data", rd_data, 8'h00);
        chk("R11 reset strobes", {6'b0, sfr_rd, sfr_wr}, 8'h00);
        acc(3'd1, 16'h0040, 1'b0, 8'h00, 2'd0);
        chk("R11 reset RAM cleared", rv, 8'h00);
    endtask

    task automatic t_banks();
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 8; r++)
                acc(3'd0, 16'(r), 1'b1, 8'(b * 8 + r) ^ 8'hA5, 2'(b));
        for (int x = 0; x < 32; x++) begin
            acc(3'd1, 16'(x), 1'b0, 8'h00, 2'd0);
            chk("R1 bank byte via direct", rv, 8'(x) ^ 8'hA5);
        end
        acc(3'd0, 16'd7, 1'b0, 8'h00, 2'd1);
        chk("R1 bank1 R7", rv, 8'h0F ^ 8'hA5);
        acc(3'd0, 16'd0, 1'b0, 8'h00, 2'd2);
        chk("R1 bank2 R0", rv, 8'h10 ^ 8'hA5);
    endtask

    task automatic t_direct_low();
        acc(3'd1, 16'h0055, 1'b1, 8'h6E, 2'd0);
        chk("R3 low direct write no strobe", {6'b0, seen_rd, seen_wr}, 8'h00);
        acc(3'd1, 16'h0055, 1'b0, 8'h00, 2'd3);
        chk("R3 low direct read", rv, 8'h6E);
    endtask

    task automatic t_indirect_vs_direct();
        acc(3'd0, 16'd0, 1'b1, 8'h90, 2'd2);
        acc(3'd2, 16'd0, 1'b1, 8'h3C, 2'd2);
        chk("R4 indirect write no strobe", {6'b0, seen_rd, seen_wr}, 8'h00);
        acc(3'd1, 16'h0090, 1'b0, 8'h00, 2'd2);
        chk("R5 direct 90h reads SFR", rv, 8'hCA);
        chk("R5 read strobe", {6'b0, seen_rd, seen_wr}, 8'h02);
        chk("R5 strobe address", seen_addr, 8'h90);
        acc(3'd2, 16'd0, 1'b0, 8'h00, 2'd2);
        chk("R4 indirect 90h reads upper RAM", rv, 8'h3C);
        acc(3'd1, 16'h0090, 1'b1, 8'h11, 2'd0);
        chk("R5 write strobe", {6'b0, seen_rd, seen_wr}, 8'h01);
        chk("R5 SFR model updated", sfr_mem[8'h90], 8'h11);
        acc(3'd2, 16'd0, 1'b0, 8'h00, 2'd2);
        chk("R4 upper RAM kept after SFR write", rv, 8'h3C);
        acc(3'd0, 16'd1, 1'b1, 8'h45, 2'd1);
        acc(3'd2, 16'd1, 1'b1, 8'h77, 2'd1);
        acc(3'd1, 16'h0045, 1'b0, 8'h00, 2'd0);
        chk("R4 R1 pointer in bank1", rv, 8'h77);
    endtask

    task automatic t_bits_ram();
        acc(3'd1, 16'h002C, 1'b1, 8'h00, 2'd0);
        acc(3'd3, 16'h0063, 1'b1, 8'h01, 2'd0);
        acc(3'd1, 16'h002C, 1'b0, 8'h00, 2'd0);
        chk("R2 bit 63h sets 2Ch bit3", rv, 8'h08);
        acc(3'd3, 16'h0063, 1'b0, 8'h00, 2'd0);
        chk("R7 bit read set", rv, 8'h01);
        acc(3'd3, 16'h0062, 1'b0, 8'h00, 2'd0);
        chk("R7 bit read clear", rv, 8'h00);
        acc(3'd1, 16'h002C, 1'b1, 8'hFF, 2'd0);
        acc(3'd3, 16'h0060, 1'b1, 8'hFE, 2'd0);
        acc(3'd1, 16'h002C, 1'b0, 8'h00, 2'd0);
        chk("R7 bit clear keeps others", rv, 8'hFE);
    endtask

    task automatic t_bits_sfr();
        acc(3'd3, 16'h00AB, 1'b1, 8'h01, 2'd0);
        chk("R6 bit write strobes rd+wr", {6'b0, seen_rd, seen_wr}, 8'h03);
        chk("R6 bit write address A8h", seen_addr, 8'hA8);
        chk("R6 SFR A8h merged", sfr_mem[8'hA8], 8'hFA);
        acc(3'd3, 16'h00A9, 1'b0, 8'h00, 2'd0);
        chk("R6 SFR bit1 read", rv, 8'h01);
        acc(3'd3, 16'h00AA, 1'b0, 8'h00, 2'd0);
        chk("R6 SFR bit2 read", rv, 8'h00);
    endtask

    task automatic t_aux();
        acc(3'd5, 16'h0000, 1'b1, 8'h5B, 2'd0);
        acc(3'd5, 16'h02FF, 1'b1, 8'h99, 2'd0);
        acc(3'd5, 16'h0300, 1'b1, 8'h12, 2'd0);
        acc(3'd5, 16'h0300, 1'b0, 8'h00, 2'd0);
        chk("R9 at size reads FF", rv, 8'hFF);
        acc(3'd5, 16'hFFFF, 1'b0, 8'h00, 2'd0);
        chk("R9 top reads FF", rv, 8'hFF);
        acc(3'd5, 16'h02FF, 1'b0, 8'h00, 2'd0);
        chk("R8 last aux byte", rv, 8'h99);
        acc(3'd5, 16'h0000, 1'b0, 8'h00, 2'd0);
        chk("R9 first byte untouched", rv, 8'h5B);
        acc(3'd0, 16'd1, 1'b1, 8'h80, 2'd3);
        acc(3'd4, 16'd1, 1'b1, 8'hC4, 2'd3);
        acc(3'd5, 16'h0080, 1'b0, 8'h00, 2'd0);
        chk("R8 R1 ext write seen by pointer", rv, 8'hC4);
        acc(3'd4, 16'd1, 1'b0, 8'h00, 2'd3);
        chk("R8 R1 ext read", rv, 8'hC4);
    endtask

    task automatic t_reserved_and_hold();
        acc(3'd1, 16'h0020, 1'b1, 8'h11, 2'd0);
        acc(3'd6, 16'h0020, 1'b1, 8'hEE, 2'd0);
        chk("R11 reserved no strobe", {6'b0, seen_rd, seen_wr}, 8'h00);
        acc(3'd7, 16'h0090, 1'b0, 8'h00, 2'd0);
        chk("R11 reserved reads 00", rv, 8'h00);
        acc(3'd1, 16'h0020, 1'b0, 8'h00, 2'd0);
        chk("R11 reserved write ignored", rv, 8'h11);
        repeat (3) @(negedge clk);
        chk("R10 hold through idle", rd_data, 8'h11);
        acc(3'd1, 16'h0021, 1'b1, 8'h42, 2'd0);
        chk("R10 hold through write", rv, 8'h11);
        acc(3'd1, 16'h0021, 1'b0, 8'h00, 2'd0);
        chk("R10 write landed, read next cycle", rv, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_banks();
        t_direct_low();
        t_indirect_vs_direct();
        t_bits_ram();
        t_bits_sfr();
        t_aux();
        t_reserved_and_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule